// File: doc/BRIEF.md
# Configuration Stream Width Finder and Sync Hunter

This block sits on the inbound path of a configuration loader and decides where the useful data in an incoming stream begins. The stream arrives either one bit per strobe on a serial input, or one beat per strobe on a parallel bus that may carry 8, 16 or 32 meaningful bits. A mode input chooses which path is live. It is held steady from the release of reset.

In parallel mode the block first works out how wide the bus is. It watches the least significant byte lane for a marker byte, and reads the width from the byte that arrives next on that lane. Once the width is known, it slides each beat into a 32-bit window and looks for the 32-bit synchronisation word. In serial mode no width is needed, so the block hunts for the same word at any bit offset. In both modes the all-ones filler words that lead the stream are passed over.

After a match, a sticky flag goes high. The block then delivers the data that follows as whole 32-bit words, each with a one-cycle valid. Any reset puts the block back into its search state, so every kind of restart can reuse the same preamble.

Top module: `cfg_sync_hunter`

## Requirements
- R1: On reset, `sync_found`, `pay_vld` and `width_err` are low and `width_code` is 2'b00 (no width found).
- R2: In parallel mode (`mode_par`=1), a valid beat with 0xBB on `par_data[7:0]` arms width detection. The next valid beat's `par_data[7:0]` then sets `width_code`: 0x11 gives 2'b01 (8-bit), 0x22 gives 2'b10 (16-bit), 0x44 gives 2'b11 (32-bit). The upper lanes are ignored, and the width holds until reset.
- R3: If any other value follows the 0xBB marker byte, the block returns to waiting for 0xBB and `width_code` stays 2'b00.
- R4: In parallel mode the sync word 0xAA995566 is searched for only after the width is known. Each new beat, using only its low 8/16/32 bits, is shifted into a 32-bit window, oldest beat most significant. The window is compared after every beat, so any number of all-ones dummy words is skipped.
- R5: `sync_found` goes high on the clock edge that accepts the last beat or bit of the sync word, and stays high until reset.
- R6: Only data after the sync word is delivered on `pay_data`. Beats are packed first beat most significant: four beats of 8 bits, two of 16 bits or one of 32 bits. `pay_vld` is high for one cycle, on the edge that accepts the word's last beat.
- R7: In serial mode (`mode_par`=0), bits on `ser_bit` are shifted in most significant bit first. The sync word is matched at any bit offset, even after only two dummy words. Payload words are aligned from the bit right after the match, and `pay_vld` fires on the 32nd bit.
- R8: In serial mode, `width_code` stays 2'b00 and `width_err` stays low, whatever the stream holds. The parallel inputs have no effect.
- R9: In parallel mode, `width_err` goes high on the edge that accepts the TIMEOUT_BEATS-th valid beat (default 64) that did not complete width detection. It stays high until reset, even if a width is found later.
- R10: A reset applied after sync clears all state, and a fresh preamble is then detected again.
- R11: Cycles in which the selected strobe (`par_vld` or `ser_vld`) is low change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; re-arms the search |
| mode_par | input | 1 | 1 = parallel bus, 0 = serial bit stream |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Serial bit strobe |
| par_data | input | 32 | Parallel beat; the low 8/16/32 bits are used according to the width |
| par_vld | input | 1 | Parallel beat strobe |
| width_code | output | 2 | 00 none, 01 8-bit, 10 16-bit, 11 32-bit |
| width_err | output | 1 | Sticky: width not found within TIMEOUT_BEATS beats |
| sync_found | output | 1 | Sticky: sync word seen |
| pay_data | output | 32 | Aligned payload word |
| pay_vld | output | 1 | One-cycle strobe for `pay_data` |

## Verification
The hardest case to reach from the ports is a narrow-bus start. In that case the marker and width bytes are followed by the rest of the detection word and then by dummy bytes, so the sync word lands at a byte offset that matches no word boundary. The bench drives the 8-bit and 16-bit preambles beat by beat, with junk on the unused upper lanes, and checks that the flag is still low one beat before the sync word completes. For the serial path, the sync word is placed three bits off any word boundary, while the parallel inputs are strobed with marker and width bytes. This shows that the match offset is free and that the width logic stays idle.

// File: rtl/cfgsync_pkg.sv
// Package: shared types and constants for the configuration sync hunter.
// Assumes a 32-bit sync word and a byte-wide width-detection lane.
package cfgsync_pkg;

    localparam int WORD_W = 32;

    // Detected bus width; the encoding is visible at the top-level port.
    typedef enum logic [1:0] {
        WC_NONE = 2'b00,
        WC_8    = 2'b01,
        WC_16   = 2'b10,
        WC_32   = 2'b11
    } width_code_t;

    localparam logic [WORD_W-1:0] SYNC_PATTERN = 32'hAA99_5566;
    localparam logic [7:0]        MARK_BYTE    = 8'hBB;
    localparam logic [7:0]        CODE_W8      = 8'h11;
    localparam logic [7:0]        CODE_W16     = 8'h22;
    localparam logic [7:0]        CODE_W32     = 8'h44;

    // Number of beats in one word, minus one, for a given width.
    function automatic logic [1:0] beats_last(width_code_t w);
        case (w)
            WC_8:    return 2'd3;
            WC_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfgsync_width_probe.sv
// Module: cfgsync_width_probe
// Finds the parallel bus width from the low byte lane. A marker byte arms
// it, and the byte on the next valid beat picks the width. Also raises a
// sticky error when no width is found within TIMEOUT_BEATS valid beats.
// Assumes en stays steady from reset; when en is low nothing changes.
module cfgsync_width_probe
    import cfgsync_pkg::*;
#(
    parameter int TIMEOUT_BEATS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        beat_vld,
    input  logic [7:0]  lane_byte,
    output width_code_t width_code,
    output logic        width_ok,
    output logic        width_err
);

    localparam int TCW = $clog2(TIMEOUT_BEATS + 1);

    typedef enum logic [1:0] {PS_SEEK, PS_CODE, PS_DONE} pstate_t;

    pstate_t        state;
    width_code_t    hit;
    logic           resolve;
    logic           take;
    logic [TCW-1:0] tcnt;

    // Decode the lane byte as a width code.
    always_comb begin
        case (lane_byte)
            CODE_W8:  hit = WC_8;
            CODE_W16: hit = WC_16;
            CODE_W32: hit = WC_32;
            default:  hit = WC_NONE;
        endcase
    end

    assign take    = en && beat_vld && (state != PS_DONE);
    assign resolve = (state == PS_CODE) && (hit != WC_NONE);

    // Marker/code state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PS_SEEK;
            width_code <= WC_NONE;
        end else if (take) begin
            case (state)
                PS_SEEK: if (lane_byte == MARK_BYTE) state <= PS_CODE;
                PS_CODE: begin
                    if (resolve) begin
                        state      <= PS_DONE;
                        width_code <= hit;
                    end else begin
                        state <= PS_SEEK;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Timeout counter over beats that did not complete detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt      <= '0;
            width_err <= 1'b0;
        end else if (take && !resolve) begin
            if (tcnt != TCW'(TIMEOUT_BEATS)) tcnt <= tcnt + 1'b1;
            if (tcnt == TCW'(TIMEOUT_BEATS - 1)) width_err <= 1'b1;
        end
    end

    assign width_ok = (state == PS_DONE);

    // R2: once found, the width never changes until reset.
    p_width_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        width_ok |=> (width_ok && $stable(width_code)));

    // R3: the width is only taken from the beat right after the marker.
    p_code_after_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(width_ok) |-> ($past(state) == PS_CODE));

    // R9: the error is sticky.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |=> width_err);

    // R9: the error only follows a full count of failing beats.
    p_err_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |-> (tcnt == TCW'(TIMEOUT_BEATS)));

endmodule

// File: rtl/cfgsync_par_hunter.sv
// Module: cfgsync_par_hunter
// Parallel path after width detection. It slides each beat into a 32-bit
// window, matches the sync word after every beat, then packs the later
// beats into aligned words. Assumes width_code is stable while width_ok.
module cfgsync_par_hunter
    import cfgsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              width_ok,
    input  width_code_t       width_code,
    input  logic              beat_vld,
    input  logic [WORD_W-1:0] beat,
    output logic              sync_hit,
    output logic [WORD_W-1:0] pay_data,
    output logic              pay_vld
);

    localparam int NW = 3;

    logic [WORD_W-1:0] win;
    logic [WORD_W-1:0] win_next;
    logic [WORD_W-1:0] cand [NW];
    logic [1:0]        bcnt;
    logic              take;

    // One shifted-window candidate per supported width: 8, 16, 32.
    for (genvar g = 0; g < NW; g++) begin : g_lane
        localparam int BW = 8 << g;
        if (BW == WORD_W) begin : g_full
            assign cand[g] = beat;
        end else begin : g_part
            assign cand[g] = {win[WORD_W-1-BW:0], beat[BW-1:0]};
        end
    end

    // Pick the candidate that matches the detected width.
    always_comb begin
        case (width_code)
            WC_8:    win_next = cand[0];
            WC_16:   win_next = cand[1];
            default: win_next = cand[2];
        endcase
    end

    assign take = en && width_ok && beat_vld;

    // Window update, sync match and payload packing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win      <= '0;
            bcnt     <= '0;
            sync_hit <= 1'b0;
            pay_data <= '0;
            pay_vld  <= 1'b0;
        end else begin
            pay_vld <= 1'b0;
            if (take) begin
                win <= win_next;
                if (!sync_hit) begin
                    if (win_next == SYNC_PATTERN) begin
                        sync_hit <= 1'b1;
                        bcnt     <= '0;
                    end
                end else if (bcnt == beats_last(width_code)) begin
                    pay_data <= win_next;
                    pay_vld  <= 1'b1;
                    bcnt     <= '0;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // R4: sync cannot be found before the width is known.
    p_sync_needs_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |-> width_ok);

    // R5: sync is sticky.
    p_par_sync_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> sync_hit);

    // R6: no payload before sync.
    p_par_pay_after_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld |-> sync_hit);

    // R11: the window holds when no beat is taken.
    p_par_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(win));

endmodule

// File: rtl/cfgsync_ser_hunter.sv
// Module: cfgsync_ser_hunter
// Serial path. It shifts bits in most significant first, matches the sync
// word at any bit offset, then emits a word every 32 bits from the bit
// after the match. Assumes one bit at most per cycle.
module cfgsync_ser_hunter
    import cfgsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic              sync_hit,
    output logic [WORD_W-1:0] pay_data,
    output logic              pay_vld
);

    localparam int BCW = $clog2(WORD_W);

    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] sr_next;
    logic [BCW-1:0]    bcnt;
    logic              take;

    assign take    = en && bit_vld;
    assign sr_next = {sr[WORD_W-2:0], bit_in};

    // Bit shift, sync match and word emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            bcnt     <= '0;
            sync_hit <= 1'b0;
            pay_data <= '0;
            pay_vld  <= 1'b0;
        end else begin
            pay_vld <= 1'b0;
            if (take) begin
                sr <= sr_next;
                if (!sync_hit) begin
                    if (sr_next == SYNC_PATTERN) begin
                        sync_hit <= 1'b1;
                        bcnt     <= '0;
                    end
                end else begin
                    bcnt <= bcnt + 1'b1;
                    if (bcnt == BCW'(WORD_W - 1)) begin
                        pay_data <= sr_next;
                        pay_vld  <= 1'b1;
                    end
                end
            end
        end
    end

    // R5: sync is sticky.
    p_ser_sync_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> sync_hit);

    // R6: no payload before sync.
    p_ser_pay_after_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld |-> sync_hit);

    // R7: words are at least 32 bits apart, so strobes never touch.
    p_ser_pay_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld |=> !pay_vld);

endmodule

// File: rtl/cfg_sync_hunter.sv
// Module: cfg_sync_hunter (top)
// Finds the start of a configuration payload in a serial or parallel
// stream. Width detection runs only in parallel mode. Each path has its own
// hunter, and the mode input picks which one drives the outputs. Assumes
// mode_par is held steady from the release of reset.
module cfg_sync_hunter
    import cfgsync_pkg::*;
#(
    parameter int TIMEOUT_BEATS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_par,
    input  logic        ser_bit,
    input  logic        ser_vld,
    input  logic [31:0] par_data,
    input  logic        par_vld,
    output logic [1:0]  width_code,
    output logic        width_err,
    output logic        sync_found,
    output logic [31:0] pay_data,
    output logic        pay_vld
);

    width_code_t       probe_code;
    logic              probe_ok;
    logic              par_sync;
    logic              ser_sync;
    logic [WORD_W-1:0] par_pay;
    logic [WORD_W-1:0] ser_pay;
    logic              par_pay_vld;
    logic              ser_pay_vld;

    cfgsync_width_probe #(.TIMEOUT_BEATS(TIMEOUT_BEATS)) u_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mode_par),
        .beat_vld   (par_vld),
        .lane_byte  (par_data[7:0]),
        .width_code (probe_code),
        .width_ok   (probe_ok),
        .width_err  (width_err)
    );

    cfgsync_par_hunter u_par (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mode_par),
        .width_ok   (probe_ok),
        .width_code (probe_code),
        .beat_vld   (par_vld),
        .beat       (par_data),
        .sync_hit   (par_sync),
        .pay_data   (par_pay),
        .pay_vld    (par_pay_vld)
    );

    cfgsync_ser_hunter u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!mode_par),
        .bit_vld  (ser_vld),
        .bit_in   (ser_bit),
        .sync_hit (ser_sync),
        .pay_data (ser_pay),
        .pay_vld  (ser_pay_vld)
    );

    // Output selection by mode.
    assign width_code = probe_code;
    assign sync_found = mode_par ? par_sync    : ser_sync;
    assign pay_data   = mode_par ? par_pay     : ser_pay;
    assign pay_vld    = mode_par ? par_pay_vld : ser_pay_vld;

    // R8: serial mode never reports a width or a width error.
    p_serial_width_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_par |-> (width_code == WC_NONE && !width_err));

endmodule

// File: tb/cfg_sync_hunter_tb.sv
// Directed bench for cfg_sync_hunter: one task per scenario.
module cfg_sync_hunter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_par;
    logic        ser_bit;
    logic        ser_vld;
    logic [31:0] par_data;
    logic        par_vld;
    logic [1:0]  width_code;
    logic        width_err;
    logic        sync_found;
    logic [31:0] pay_data;
    logic        pay_vld;

    int n_chk  = 0;
    int n_fail = 0;
    logic noise_t = 1'b0;

    always #2 clk = ~clk;

    cfg_sync_hunter #(.TIMEOUT_BEATS(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_par),
        .ser_bit(ser_bit), .ser_vld(ser_vld),
        .par_data(par_data), .par_vld(par_vld),
        .width_code(width_code), .width_err(width_err),
        .sync_found(sync_found), .pay_data(pay_data), .pay_vld(pay_vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reset_dut(input logic par);
        @(negedge clk);
        rst_n = 1'b0; mode_par = par;
        ser_bit = 1'b0; ser_vld = 1'b0; par_data = '0; par_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pbeat(input logic [31:0] d);
        par_data = d; par_vld = 1'b1;
        @(negedge clk);
        par_vld = 1'b0;
    endtask

    task automatic sbit(input logic b);
        ser_bit = b; ser_vld = 1'b1;
        par_vld = 1'b1; par_data = noise_t ? 32'h44 : 32'hBB;
        noise_t = ~noise_t;
        @(negedge clk);
        ser_vld = 1'b0; par_vld = 1'b0;
    endtask

    task automatic sword(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) sbit(w[i]);
    endtask

    task automatic t_reset_state();
        reset_dut(1'b1);
        chk("R1 sync", {31'b0, sync_found}, 32'd0);
        chk("R1 width", {30'b0, width_code}, 32'd0);
        chk("R1 pay_vld", {31'b0, pay_vld}, 32'd0);
        chk("R1 err", {31'b0, width_err}, 32'd0);
    endtask

    task automatic t_par32();
        reset_dut(1'b1);
        for (int i = 0; i < 8; i++) pbeat(32'hFFFF_FFFF);
        pbeat(32'h0000_00BB);
        pbeat(32'h1122_0044);
        chk("R2 width32", {30'b0, width_code}, 32'd3);
        pbeat(32'hFFFF_FFFF); pbeat(32'hFFFF_FFFF);
        chk("R4 dummies skipped", {31'b0, sync_found}, 32'd0);
        pbeat(32'hAA99_5566);
        chk("R5 sync set", {31'b0, sync_found}, 32'd1);
        chk("R6 sync word not payload", {31'b0, pay_vld}, 32'd0);
        pbeat(32'h1234_5678);
        chk("R6 pay32 vld", {31'b0, pay_vld}, 32'd1);
        chk("R6 pay32 data", pay_data, 32'h1234_5678);
        @(negedge clk);
        chk("R11 idle no pay", {31'b0, pay_vld}, 32'd0);
        chk("R5 sticky", {31'b0, sync_found}, 32'd1);
        chk("R9 no err", {31'b0, width_err}, 32'd0);
    endtask

    task automatic t_rearm();
        reset_dut(1'b1);
        chk("R10 sync cleared", {31'b0, sync_found}, 32'd0);
        chk("R10 width cleared", {30'b0, width_code}, 32'd0);
        pbeat(32'hFFFF_FFFF); pbeat(32'h0000_00BB); pbeat(32'h1122_0044);
        pbeat(32'hFFFF_FFFF); pbeat(32'hAA99_5566);
        chk("R10 resync", {31'b0, sync_found}, 32'd1);
    endtask

    task automatic t_par8();
        logic [7:0] pre [12] = '{8'hFF, 8'hFF, 8'hBB, 8'h11, 8'h22, 8'h00,
                                 8'h44, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h99};
        reset_dut(1'b1);
        for (int i = 0; i < 12; i++) pbeat({24'hABCDEF, pre[i]});
        chk("R2 width8", {30'b0, width_code}, 32'd1);
        pbeat({24'hABCDEF, 8'h55});
        chk("R4 byte offset no early sync", {31'b0, sync_found}, 32'd0);
        pbeat({24'hABCDEF, 8'h66});
        chk("R5 sync8", {31'b0, sync_found}, 32'd1);
        pbeat({24'h123456, 8'hDE}); pbeat({24'h123456, 8'hAD});
        pbeat({24'h123456, 8'hBE});
        chk("R6 pay8 partial", {31'b0, pay_vld}, 32'd0);
        pbeat({24'h123456, 8'hEF});
        chk("R6 pay8 vld", {31'b0, pay_vld}, 32'd1);
        chk("R6 pay8 data", pay_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_par16();
        reset_dut(1'b1);
        pbeat(32'h5A5A_FFFF); pbeat(32'h5A5A_00BB); pbeat(32'h5A5A_1122);
        chk("R2 width16", {30'b0, width_code}, 32'd2);
        pbeat(32'h5A5A_0044);
        for (int i = 0; i < 4; i++) pbeat(32'h5A5A_FFFF);
        pbeat(32'h5A5A_AA99);
        chk("R4 half word no sync", {31'b0, sync_found}, 32'd0);
        pbeat(32'h5A5A_5566);
        chk("R5 sync16", {31'b0, sync_found}, 32'd1);
        pbeat(32'h0000_CAFE);
        chk("R6 pay16 partial", {31'b0, pay_vld}, 32'd0);
        pbeat(32'h0000_F00D);
        chk("R6 pay16 data", pay_data, 32'hCAFE_F00D);
    endtask

    task automatic t_bad_code();
        reset_dut(1'b1);
        pbeat(32'hAA99_5566);
        chk("R4 no sync before width", {31'b0, sync_found}, 32'd0);
        pbeat(32'h0000_00BB); pbeat(32'h0000_0033);
        chk("R3 bad code rejected", {30'b0, width_code}, 32'd0);
        pbeat(32'h0000_0022);
        chk("R3 needs new marker", {30'b0, width_code}, 32'd0);
        pbeat(32'h0000_00BB);
        par_data = 32'h0000_0044; par_vld = 1'b0;
        @(negedge clk);
        chk("R11 unstrobed code ignored", {30'b0, width_code}, 32'd0);
        pbeat(32'h0000_0022);
        chk("R11 next valid beat sets width", {30'b0, width_code}, 32'd2);
    endtask

    task automatic t_timeout();
        reset_dut(1'b1);
        for (int i = 0; i < 63; i++) pbeat(32'hFFFF_FFFF);
        chk("R9 no err at 63", {31'b0, width_err}, 32'd0);
        pbeat(32'hFFFF_FFFF);
        chk("R9 err at 64", {31'b0, width_err}, 32'd1);
        pbeat(32'h0000_00BB); pbeat(32'h0000_0044);
        chk("R9 late width found", {30'b0, width_code}, 32'd3);
        chk("R9 err sticky", {31'b0, width_err}, 32'd1);
    endtask

    task automatic t_serial();
        logic [31:0] syncw = 32'hAA99_5566;
        logic [31:0] payw  = 32'h0F1E_2D3C;
        reset_dut(1'b0);
        for (int i = 0; i < 8; i++) sword(32'hFFFF_FFFF);
        sword(32'h0000_00BB); sword(32'h1122_0044);
        sword(32'hFFFF_FFFF); sword(32'hFFFF_FFFF);
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        for (int i = 31; i >= 1; i--) sbit(syncw[i]);
        chk("R7 no early serial sync", {31'b0, sync_found}, 32'd0);
        sbit(syncw[0]);
        chk("R7 serial sync at offset", {31'b0, sync_found}, 32'd1);
        chk("R8 serial width idle", {30'b0, width_code}, 32'd0);
        chk("R8 serial no err", {31'b0, width_err}, 32'd0);
        for (int i = 31; i >= 1; i--) sbit(payw[i]);
        chk("R7 serial pay partial", {31'b0, pay_vld}, 32'd0);
        sbit(payw[0]);
        chk("R7 serial pay vld", {31'b0, pay_vld}, 32'd1);
        chk("R7 serial pay data", pay_data, payw);
    endtask

    task automatic t_serial_short();
        reset_dut(1'b0);
        sword(32'hFFFF_FFFF); sword(32'hFFFF_FFFF);
        sword(32'hAA99_5566);
        chk("R7 short lead-in", {31'b0, sync_found}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; mode_par = 1'b1; ser_bit = 1'b0; ser_vld = 1'b0;
        par_data = '0; par_vld = 1'b0;
        t_reset_state();
        t_par32();
        t_rearm();
        t_par8();
        t_par16();
        t_bad_code();
        t_timeout();
        t_serial();
        t_serial_short();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule